// File: doc/BRIEF.md
# Wormhole Mesh Router with Virtual Channels

This block is one router of a two-dimensional mesh network-on-chip. It has five ports (a local port towards the attached core and four neighbour ports), each carrying flits on a data path of `W` bits, 32 by default. A packet is a head flit followed by any number of body flits and a closing tail flit, or it is one flit marked single. The head selects an output port from its destination coordinates and the router's own coordinates. That output then stays reserved for the packet until the tail has gone through.

Every input keeps `NVC` virtual-channel queues of `VC_DEPTH` flits each. An arriving head claims a free queue at its input, and the body and tail flits that follow go into the same queue. A static mode input picks one of three routing orders: dimension order (X then Y), west-first, or north-last. When several inputs compete for one output, a round-robin arbiter settles it. Flow control on each link is a per-flit acknowledge or refusal. A refused flit stays with its sender, which offers it again. The router answers its upstream neighbours in the same cycle. Towards downstream, it holds a flit in the output register until that flit is acknowledged.

Top module: `mesh_router`

## Requirements
- R1: While `rst_n` is low, no output valid is raised. After reset no packet is open, every queue is empty and every output is unreserved.
- R2: The flit kind sits in bits [W-1:W-2]: 2'b01 head, 2'b00 body, 2'b10 tail, 2'b11 single. Destination X is in [W-3:W-6] and destination Y is in [W-7:W-10]. Port indices are 0 local, 1 north (Y+1), 2 east (X+1), 3 south (Y-1), 4 west (X-1).
- R3: With `routeMode`=0, a packet moves east or west until X matches, then north or south until Y matches. It leaves on the local port when both X and Y match.
- R4: With `routeMode`=1, a packet that needs a westward hop always takes west. Otherwise the router tries north, then south, then east, then local.
- R5: With `routeMode`=2, the router tries south, then east, then west, and takes north only when no other hop remains. It takes local when both coordinates match.
- R6: All flits of a packet leave on the output its head chose, in order, with no other packet's flits in between. The output is freed only once the tail has been forwarded.
- R7: A head or single flit is acknowledged when a free virtual channel exists at its input and takes the lowest-numbered free one. It is refused when all `NVC` channels are occupied. A channel becomes free when its tail or single flit is forwarded.
- R8: A body or tail flit goes into the channel opened by its input's latest head and is refused if that channel is full. At an input with no open packet it is refused and never forwarded.
- R9: Each output's arbiter searches inputs in rising index order, starting from the input just past the last winner.
- R10: While downstream refuses, or does not acknowledge, a presented flit, the output keeps its valid and its flit unchanged and offers it again.
- R11: In every cycle, each input with valid raised gets exactly one of acknowledge or refusal, combinationally in that cycle. An input without valid gets neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| routeMode | input | 2 | 0 dimension order, 1 west-first, 2 north-last (3 acts as 0) |
| myX | input | 4 | X coordinate of this router |
| myY | input | 4 | Y coordinate of this router |
| inValid | input | 5 | Flit offered on each input port |
| inFlit | input | 5*W | Input flits, port p at bits [p*W +: W] |
| inAck | output | 5 | Flit accepted on that input this cycle |
| inNack | output | 5 | Flit refused on that input this cycle |
| outValid | output | 5 | Flit presented on each output port |
| outFlit | output | 5*W | Output flits, port p at bits [p*W +: W] |
| outAck | input | 5 | Downstream accepts the presented flit |
| outNack | input | 5 | Downstream refuses the presented flit |

## Verification
The bench sends identical destinations under all three routing modes. A router that ignored the mode, or that tried directions in the wrong order, sends some flit out of the wrong port. Two packets are interleaved flit by flit on two inputs towards one output. A router that freed the output early, or arbitrated per flit, mixes the packets on that output. A blocked output is filled until every queue at one input is occupied; a wrong capacity count acknowledges the sixth head, and a broken refusal hold changes or drops the waiting flit. The arbiter test starts from a pointer that a fixed-priority arbiter would ignore, so such an arbiter delivers the flits in a different order. A stray body flit at an idle input must be refused; a router that did not check this would let the flit through.

// File: rtl/router_pkg.sv
package router_pkg;

  localparam int NUM_PORTS = 5;
  localparam int VC_ID_W   = 4;

  localparam logic [2:0] PORT_LOCAL = 3'd0;
  localparam logic [2:0] PORT_NORTH = 3'd1;
  localparam logic [2:0] PORT_EAST  = 3'd2;
  localparam logic [2:0] PORT_SOUTH = 3'd3;
  localparam logic [2:0] PORT_WEST  = 3'd4;

  typedef enum logic [1:0] {
    FK_BODY   = 2'b00,
    FK_HEAD   = 2'b01,
    FK_TAIL   = 2'b10,
    FK_SINGLE = 2'b11
  } flit_kind_e;

  typedef enum logic [1:0] {
    RM_DIM_ORDER  = 2'd0,
    RM_WEST_FIRST = 2'd1,
    RM_NORTH_LAST = 2'd2
  } route_mode_e;

  typedef struct packed {
    logic               push;
    logic [VC_ID_W-1:0] pushVc;
    logic               pop;
    logic [VC_ID_W-1:0] popVc;
  } in_strobe_t;

  typedef struct packed {
    logic               load;
    logic [2:0]         srcPort;
    logic [VC_ID_W-1:0] srcVc;
  } out_strobe_t;

  typedef struct packed {
    in_strobe_t  [NUM_PORTS-1:0] inS;
    out_strobe_t [NUM_PORTS-1:0] outS;
  } router_strobe_t;

  function automatic logic [2:0] pickPort(input logic [1:0] mode,
                                          input logic [3:0] curX, input logic [3:0] curY,
                                          input logic [3:0] dstX, input logic [3:0] dstY);
    logic goE, goW, goN, goS;
    logic [2:0] sel;
    goE = dstX > curX;
    goW = dstX < curX;
    goN = dstY > curY;
    goS = dstY < curY;
    case (mode)
      RM_WEST_FIRST: begin
        if (goW)      sel = PORT_WEST;
        else if (goN) sel = PORT_NORTH;
        else if (goS) sel = PORT_SOUTH;
        else if (goE) sel = PORT_EAST;
        else          sel = PORT_LOCAL;
      end
      RM_NORTH_LAST: begin
        if (goS)      sel = PORT_SOUTH;
        else if (goE) sel = PORT_EAST;
        else if (goW) sel = PORT_WEST;
        else if (goN) sel = PORT_NORTH;
        else          sel = PORT_LOCAL;
      end
      default: begin
        if (goE)      sel = PORT_EAST;
        else if (goW) sel = PORT_WEST;
        else if (goN) sel = PORT_NORTH;
        else if (goS) sel = PORT_SOUTH;
        else          sel = PORT_LOCAL;
      end
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/router_vc_fifo.sv
module router_vc_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/router_datapath.sv
module router_datapath
  import router_pkg::*;
#(
  parameter int W        = 32,
  parameter int NVC      = 4,
  parameter int VC_DEPTH = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  router_strobe_t                         strobe,
  input  logic [NUM_PORTS-1:0][W-1:0]            inFlit,
  input  logic [NUM_PORTS-1:0]                   outAck,
  input  logic [NUM_PORTS-1:0]                   outNack,
  output logic [NUM_PORTS-1:0][NVC-1:0][W-1:0]   frontFlit,
  output logic [NUM_PORTS-1:0][NVC-1:0]          vcEmpty,
  output logic [NUM_PORTS-1:0][NVC-1:0]          vcFull,
  output logic [NUM_PORTS-1:0]                   outValid,
  output logic [NUM_PORTS-1:0][W-1:0]            outFlit,
  output logic [NUM_PORTS-1:0]                   outReady
);
  localparam int VCW = (NVC > 1) ? $clog2(NVC) : 1;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_in
    for (genvar v = 0; v < NVC; v++) begin : g_vc
      logic doPush, doPop;
      assign doPush = strobe.inS[i].push && (strobe.inS[i].pushVc == VC_ID_W'(v));
      assign doPop  = strobe.inS[i].pop  && (strobe.inS[i].popVc  == VC_ID_W'(v));
      router_vc_fifo #(.W(W), .DEPTH(VC_DEPTH)) i_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (doPush),
        .pop    (doPop),
        .wrData (inFlit[i]),
        .rdData (frontFlit[i][v]),
        .empty  (vcEmpty[i][v]),
        .full   (vcFull[i][v])
      );
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_out
    logic drained;
    assign drained     = outAck[p] && !outNack[p];
    assign outReady[p] = !outValid[p] || drained;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        outValid[p] <= 1'b0;
        outFlit[p]  <= '0;
      end else if (strobe.outS[p].load) begin
        outValid[p] <= 1'b1;
        outFlit[p]  <= frontFlit[strobe.outS[p].srcPort][strobe.outS[p].srcVc[VCW-1:0]];
      end else if (drained) begin
        outValid[p] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/router_control.sv
module router_control
  import router_pkg::*;
#(
  parameter int W   = 32,
  parameter int NVC = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [1:0]                           routeMode,
  input  logic [3:0]                           myX,
  input  logic [3:0]                           myY,
  input  logic [NUM_PORTS-1:0]                 inValid,
  input  logic [NUM_PORTS-1:0][W-1:0]          inFlit,
  input  logic [NUM_PORTS-1:0][NVC-1:0][W-1:0] frontFlit,
  input  logic [NUM_PORTS-1:0][NVC-1:0]        vcEmpty,
  input  logic [NUM_PORTS-1:0][NVC-1:0]        vcFull,
  input  logic [NUM_PORTS-1:0]                 outReady,
  output router_strobe_t                       strobe,
  output logic [NUM_PORTS-1:0]                 inAck,
  output logic [NUM_PORTS-1:0]                 inNack
);
  localparam int VCW = (NVC > 1) ? $clog2(NVC) : 1;

  // per-channel and per-input state
  logic [NUM_PORTS-1:0][NVC-1:0] vcBusy, vcRouted;
  logic [2:0]     vcRoute [NUM_PORTS][NVC];
  logic [NUM_PORTS-1:0] fillOpen, lockValid;
  logic [VCW-1:0] fillVc  [NUM_PORTS];
  logic [VCW-1:0] vcPtr   [NUM_PORTS];
  logic [2:0]     rrPtr   [NUM_PORTS];

  // combinational decisions
  logic [NUM_PORTS-1:0] accept;
  logic [VCW-1:0] pushSel [NUM_PORTS];
  logic [NUM_PORTS-1:0][NVC-1:0] elig;
  logic [2:0]     wantPort [NUM_PORTS][NVC];
  logic [NUM_PORTS-1:0] candValid;
  logic [VCW-1:0] cand     [NUM_PORTS];
  logic [2:0]     candPort [NUM_PORTS];
  logic [NUM_PORTS-1:0] outGrant, inGrant;
  logic [2:0]     outWinner [NUM_PORTS];

  // admission of arriving flits
  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      logic freeOk;
      logic [VCW-1:0] freeIdx;
      logic [1:0] kind;
      freeOk  = 1'b0;
      freeIdx = '0;
      kind    = inFlit[i][W-1 -: 2];
      for (int v = NVC - 1; v >= 0; v--) begin
        if (!vcBusy[i][v]) begin
          freeOk  = 1'b1;
          freeIdx = VCW'(v);
        end
      end
      if (kind == FK_HEAD || kind == FK_SINGLE) begin
        accept[i]  = freeOk;
        pushSel[i] = freeIdx;
      end else begin
        accept[i]  = fillOpen[i] && !vcFull[i][fillVc[i]];
        pushSel[i] = fillVc[i];
      end
      inAck[i]  = inValid[i] && accept[i];
      inNack[i] = inValid[i] && !accept[i];
    end
  end

  // route lookup and eligibility of each channel front
  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      for (int v = 0; v < NVC; v++) begin
        logic [1:0] kind;
        logic startOk;
        kind = frontFlit[i][v][W-1 -: 2];
        wantPort[i][v] = vcRouted[i][v] ? vcRoute[i][v]
                       : pickPort(routeMode, myX, myY,
                                  frontFlit[i][v][W-3 -: 4], frontFlit[i][v][W-7 -: 4]);
        startOk = (kind == FK_HEAD || kind == FK_SINGLE) && !lockValid[wantPort[i][v]];
        elig[i][v] = !vcEmpty[i][v] && outReady[wantPort[i][v]] && (vcRouted[i][v] || startOk);
      end
    end
  end

  // per-input channel pick, rotating from vcPtr
  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      candValid[i] = 1'b0;
      cand[i]      = '0;
      for (int k = 0; k < NVC; k++) begin
        int idx;
        idx = (int'(vcPtr[i]) + k) % NVC;
        if (!candValid[i] && elig[i][idx]) begin
          candValid[i] = 1'b1;
          cand[i]      = VCW'(idx);
        end
      end
      candPort[i] = wantPort[i][cand[i]];
    end
  end

  // per-output round-robin over inputs
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      outGrant[p]  = 1'b0;
      outWinner[p] = '0;
      for (int k = 0; k < NUM_PORTS; k++) begin
        int idx;
        idx = (int'(rrPtr[p]) + k) % NUM_PORTS;
        if (!outGrant[p] && candValid[idx] && candPort[idx] == 3'(p)) begin
          outGrant[p]  = 1'b1;
          outWinner[p] = 3'(idx);
        end
      end
    end
    for (int i = 0; i < NUM_PORTS; i++) begin
      inGrant[i] = candValid[i] && outGrant[candPort[i]] && (outWinner[candPort[i]] == 3'(i));
    end
  end

  // strobes to the datapath
  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      strobe.inS[i].push   = inAck[i];
      strobe.inS[i].pushVc = VC_ID_W'(pushSel[i]);
      strobe.inS[i].pop    = inGrant[i];
      strobe.inS[i].popVc  = VC_ID_W'(cand[i]);
    end
    for (int p = 0; p < NUM_PORTS; p++) begin
      strobe.outS[p].load    = outGrant[p];
      strobe.outS[p].srcPort = outWinner[p];
      strobe.outS[p].srcVc   = VC_ID_W'(cand[outWinner[p]]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcBusy    <= '0;
      vcRouted  <= '0;
      fillOpen  <= '0;
      lockValid <= '0;
      for (int i = 0; i < NUM_PORTS; i++) begin
        fillVc[i] <= '0;
        vcPtr[i]  <= '0;
        rrPtr[i]  <= '0;
        for (int v = 0; v < NVC; v++) vcRoute[i][v] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        if (inAck[i]) begin
          case (inFlit[i][W-1 -: 2])
            FK_HEAD: begin
              vcBusy[i][pushSel[i]] <= 1'b1;
              fillOpen[i]           <= 1'b1;
              fillVc[i]             <= pushSel[i];
            end
            FK_SINGLE: vcBusy[i][pushSel[i]] <= 1'b1;
            FK_TAIL:   fillOpen[i] <= 1'b0;
            default: ;
          endcase
        end
        if (inGrant[i]) begin
          case (frontFlit[i][cand[i]][W-1 -: 2])
            FK_HEAD: begin
              vcRouted[i][cand[i]]   <= 1'b1;
              vcRoute[i][cand[i]]    <= candPort[i];
              lockValid[candPort[i]] <= 1'b1;
            end
            FK_TAIL: begin
              vcRouted[i][cand[i]]   <= 1'b0;
              lockValid[candPort[i]] <= 1'b0;
              vcBusy[i][cand[i]]     <= 1'b0;
            end
            FK_SINGLE: vcBusy[i][cand[i]] <= 1'b0;
            default: ;
          endcase
          vcPtr[i] <= (int'(cand[i]) == NVC - 1) ? '0 : cand[i] + 1'b1;
          rrPtr[candPort[i]] <= (i == NUM_PORTS - 1) ? 3'd0 : 3'(i + 1);
        end
      end
    end
  end
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import router_pkg::*;
#(
  parameter int W        = 32,
  parameter int NVC      = 4,
  parameter int VC_DEPTH = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             routeMode,
  input  logic [3:0]             myX,
  input  logic [3:0]             myY,
  input  logic [NUM_PORTS-1:0]   inValid,
  input  logic [NUM_PORTS*W-1:0] inFlit,
  output logic [NUM_PORTS-1:0]   inAck,
  output logic [NUM_PORTS-1:0]   inNack,
  output logic [NUM_PORTS-1:0]   outValid,
  output logic [NUM_PORTS*W-1:0] outFlit,
  input  logic [NUM_PORTS-1:0]   outAck,
  input  logic [NUM_PORTS-1:0]   outNack
);
  router_strobe_t                       strobe;
  logic [NUM_PORTS-1:0][W-1:0]          inFlitA, outFlitA;
  logic [NUM_PORTS-1:0][NVC-1:0][W-1:0] frontFlit;
  logic [NUM_PORTS-1:0][NVC-1:0]        vcEmpty, vcFull;
  logic [NUM_PORTS-1:0]                 outReady;

  assign inFlitA = inFlit;
  assign outFlit = outFlitA;

  router_control #(.W(W), .NVC(NVC)) i_control (
    .clk       (clk),
    .rst_n     (rst_n),
    .routeMode (routeMode),
    .myX       (myX),
    .myY       (myY),
    .inValid   (inValid),
    .inFlit    (inFlitA),
    .frontFlit (frontFlit),
    .vcEmpty   (vcEmpty),
    .vcFull    (vcFull),
    .outReady  (outReady),
    .strobe    (strobe),
    .inAck     (inAck),
    .inNack    (inNack)
  );

  router_datapath #(.W(W), .NVC(NVC), .VC_DEPTH(VC_DEPTH)) i_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .inFlit    (inFlitA),
    .outAck    (outAck),
    .outNack   (outNack),
    .frontFlit (frontFlit),
    .vcEmpty   (vcEmpty),
    .vcFull    (vcFull),
    .outValid  (outValid),
    .outFlit   (outFlitA),
    .outReady  (outReady)
  );
endmodule

// File: rtl/router_checker.sv
module router_checker #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     routeMode,
  input logic [3:0]     myX,
  input logic [3:0]     myY,
  input logic [4:0]     inValid,
  input logic [4:0]     inAck,
  input logic [4:0]     inNack,
  input logic [4:0]     outValid,
  input logic [5*W-1:0] outFlit,
  input logic [4:0]     outAck,
  input logic [4:0]     outNack
);
  logic [4:0] inPkt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inPkt <= '0;
    else begin
      for (int p = 0; p < 5; p++) begin
        if (outValid[p] && outAck[p] && !outNack[p]) begin
          if (outFlit[p*W + W - 1 -: 2] == 2'b01)      inPkt[p] <= 1'b1;
          else if (outFlit[p*W + W - 1 -: 2] == 2'b10) inPkt[p] <= 1'b0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) assert_reset_quiet_R1: assert (outValid == 5'b0);
  end

  for (genvar p = 0; p < 5; p++) begin : g_port
    logic [1:0] kind;
    logic [3:0] dX, dY;
    logic       starts;
    assign kind   = outFlit[p*W + W - 1 -: 2];
    assign dX     = outFlit[p*W + W - 3 -: 4];
    assign dY     = outFlit[p*W + W - 7 -: 4];
    assign starts = (kind == 2'b01) || (kind == 2'b11);

    assert_hold_on_nack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (outValid[p] && !(outAck[p] && !outNack[p])) |=> (outValid[p] && $stable(outFlit[p*W +: W])));

    assert_one_answer_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((inAck[p] | inNack[p]) == inValid[p]) && !(inAck[p] && inNack[p]));

    assert_packet_body_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (outValid[p] && inPkt[p]) |-> (kind == 2'b00 || kind == 2'b10));

    assert_packet_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (outValid[p] && !inPkt[p]) |-> starts);

    if (p == 0) begin : g_local
      assert_local_eject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (outValid[p] && starts) |-> (dX == myX && dY == myY));
    end

    if (p >= 1 && p <= 3) begin : g_nonwest
      assert_west_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (routeMode == 2'd1 && outValid[p] && starts) |-> (dX >= myX));
    end
  end
endmodule

bind mesh_router router_checker #(.W(W)) i_router_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .routeMode (routeMode),
  .myX       (myX),
  .myY       (myY),
  .inValid   (inValid),
  .inAck     (inAck),
  .inNack    (inNack),
  .outValid  (outValid),
  .outFlit   (outFlit),
  .outAck    (outAck),
  .outNack   (outNack)
);

// File: tb/test_mesh_router.sv
module test_mesh_router;
  localparam int W = 32;
  localparam int LOC = 0, NOR = 1, EAS = 2, SOU = 3, WES = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   routeMode = 2'd0;
  logic [3:0]   myX = 4'd2, myY = 4'd2;
  logic [4:0]   inValid = '0;
  logic [5*W-1:0] inFlit = '0;
  logic [4:0]   inAck, inNack, outValid, outAck, outNack;
  logic [5*W-1:0] outFlit;
  logic [4:0]   sinkHold = '0;

  int errors = 0, checks = 0;
  logic [W-1:0] logQ [5][$];

  always #10 clk = ~clk;

  assign outAck  = outValid & ~sinkHold;
  assign outNack = outValid & sinkHold;

  mesh_router #(.W(W), .NVC(4), .VC_DEPTH(2)) i_mesh_router (
    .clk(clk), .rst_n(rst_n), .routeMode(routeMode), .myX(myX), .myY(myY),
    .inValid(inValid), .inFlit(inFlit), .inAck(inAck), .inNack(inNack),
    .outValid(outValid), .outFlit(outFlit), .outAck(outAck), .outNack(outNack));

  always @(negedge clk) begin
    for (int p = 0; p < 5; p++)
      if (outValid[p] && outAck[p]) logQ[p].push_back(outFlit[p*W +: W]);
  end

  function automatic logic [W-1:0] mk(input logic [1:0] k, input logic [3:0] x,
                                      input logic [3:0] y, input logic [21:0] pay);
    return {k, x, y, pay};
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearLogs();
    for (int p = 0; p < 5; p++) logQ[p].delete();
  endtask

  task automatic sendFlit(input int p, input logic [W-1:0] f, output bit acked, output bit nacked);
    @(negedge clk);
    inValid[p] = 1'b1;
    inFlit[p*W +: W] = f;
    #1;
    acked  = inAck[p];
    nacked = inNack[p];
    @(posedge clk);
    #1 inValid[p] = 1'b0;
  endtask

  task automatic sendRetry(input int p, input logic [W-1:0] f);
    bit a, n;
    for (int t = 0; t < 50; t++) begin
      sendFlit(p, f, a, n);
      if (a) return;
    end
    check(1'b0, "R8 sendRetry", 32'(n), 32'h1);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic routeOne(input logic [1:0] mode, input int inP, input logic [3:0] x,
                          input logic [3:0] y, input int expP, input string req);
    logic [W-1:0] f;
    int total;
    routeMode = mode;
    clearLogs();
    f = mk(2'b11, x, y, 22'(inP * 16 + x * 4 + y));
    sendRetry(inP, f);
    waitCycles(4);
    total = 0;
    for (int p = 0; p < 5; p++) total += logQ[p].size();
    check(logQ[expP].size() == 1 && total == 1 && logQ[expP][0] == f,
          req, 32'(total), 32'(expP));
  endtask

  task automatic testReset();
    rst_n = 1'b0;
    waitCycles(3);
    check(outValid == 5'b0, "R1 outValid in reset", 32'(outValid), 0);
    check(inAck == 5'b0 && inNack == 5'b0, "R1 no answer in reset", 32'({inAck, inNack}), 0);
    rst_n = 1'b1;
    waitCycles(2);
    check(outValid == 5'b0, "R1 outValid after reset", 32'(outValid), 0);
  endtask

  task automatic testDimOrder();
    routeOne(2'd0, LOC, 4'd3, 4'd1, EAS, "R3/R2 XY east first");
    routeOne(2'd0, LOC, 4'd1, 4'd3, WES, "R3 XY west first");
    routeOne(2'd0, LOC, 4'd2, 4'd3, NOR, "R3 XY north");
    routeOne(2'd0, LOC, 4'd2, 4'd1, SOU, "R3 XY south");
    routeOne(2'd0, NOR, 4'd2, 4'd2, LOC, "R3 XY local eject");
  endtask

  task automatic testWestFirst();
    routeOne(2'd1, LOC, 4'd3, 4'd3, NOR, "R4 west-first north before east");
    routeOne(2'd1, LOC, 4'd1, 4'd3, WES, "R4 west-first west");
    routeOne(2'd1, LOC, 4'd3, 4'd1, SOU, "R4 west-first south before east");
  endtask

  task automatic testNorthLast();
    routeOne(2'd2, LOC, 4'd3, 4'd1, SOU, "R5 north-last south first");
    routeOne(2'd2, LOC, 4'd3, 4'd3, EAS, "R5 north-last east before north");
    routeOne(2'd2, LOC, 4'd1, 4'd1, SOU, "R5 north-last south before west");
    routeOne(2'd2, LOC, 4'd2, 4'd3, NOR, "R5 north-last north at end");
    routeMode = 2'd0;
  endtask

  task automatic testWormhole();
    logic [W-1:0] pk [4];
    logic [W-1:0] s;
    clearLogs();
    pk[0] = mk(2'b01, 4'd3, 4'd2, 22'h100);
    pk[1] = mk(2'b00, 4'd0, 4'd0, 22'h101);
    pk[2] = mk(2'b00, 4'd0, 4'd0, 22'h102);
    pk[3] = mk(2'b10, 4'd0, 4'd0, 22'h103);
    for (int k = 0; k < 4; k++) sendRetry(WES, pk[k]);
    waitCycles(5);
    check(logQ[EAS].size() == 4, "R6 packet flit count", 32'(logQ[EAS].size()), 4);
    for (int k = 0; k < 4 && k < logQ[EAS].size(); k++)
      check(logQ[EAS][k] == pk[k], "R6 packet order", logQ[EAS][k], pk[k]);
    s = mk(2'b11, 4'd3, 4'd2, 22'h1ff);
    sendRetry(LOC, s);
    waitCycles(4);
    check(logQ[EAS].size() == 5 && logQ[EAS][4] == s, "R6 output freed after tail",
          32'(logQ[EAS].size()), 5);
  endtask

  task automatic testInterleave();
    logic [W-1:0] nP [3];
    logic [W-1:0] sP [3];
    clearLogs();
    nP[0] = mk(2'b01, 4'd3, 4'd2, 22'h200); sP[0] = mk(2'b01, 4'd3, 4'd2, 22'h300);
    nP[1] = mk(2'b00, 4'd0, 4'd0, 22'h201); sP[1] = mk(2'b00, 4'd0, 4'd0, 22'h301);
    nP[2] = mk(2'b10, 4'd0, 4'd0, 22'h202); sP[2] = mk(2'b10, 4'd0, 4'd0, 22'h302);
    for (int k = 0; k < 3; k++) begin
      sendRetry(NOR, nP[k]);
      sendRetry(SOU, sP[k]);
    end
    waitCycles(8);
    check(logQ[EAS].size() == 6, "R6 two packets count", 32'(logQ[EAS].size()), 6);
    for (int k = 0; k < 3 && logQ[EAS].size() == 6; k++) begin
      check(logQ[EAS][k] == nP[k], "R6 first packet contiguous", logQ[EAS][k], nP[k]);
      check(logQ[EAS][k+3] == sP[k], "R6 second packet after tail", logQ[EAS][k+3], sP[k]);
    end
  endtask

  task automatic testVcFull();
    logic [W-1:0] s [6];
    bit a, n;
    int seen;
    clearLogs();
    sinkHold[EAS] = 1'b1;
    for (int k = 0; k < 6; k++) s[k] = mk(2'b11, 4'd3, 4'd2, 22'(16'h400 + k));
    for (int k = 0; k < 6; k++) begin
      sendFlit(LOC, s[k], a, n);
      check(a == (k < 5) && n == (k == 5), k < 5 ? "R7 head takes free channel" : "R7 no free channel NACK",
            32'({a, n}), (k < 5) ? 32'h2 : 32'h1);
      check(a ^ n, "R11 one answer", 32'({a, n}), 32'h2);
    end
    for (int c = 0; c < 3; c++) begin
      waitCycles(1);
      check(outValid[EAS] && outFlit[EAS*W +: W] == s[0], "R10 flit held under NACK",
            outFlit[EAS*W +: W], s[0]);
    end
    check(logQ[EAS].size() == 0, "R10 nothing consumed under NACK", 32'(logQ[EAS].size()), 0);
    sinkHold[EAS] = 1'b0;
    waitCycles(10);
    check(logQ[EAS].size() == 5, "R7 all accepted flits delivered", 32'(logQ[EAS].size()), 5);
    if (logQ[EAS].size() > 0)
      check(logQ[EAS][0] == s[0], "R10 held flit offered again", logQ[EAS][0], s[0]);
    seen = 0;
    for (int k = 0; k < 5; k++)
      foreach (logQ[EAS][j]) if (logQ[EAS][j] == s[k]) seen++;
    check(seen == 5, "R7 each accepted flit once", 32'(seen), 5);
  endtask

  task automatic testRoundRobin();
    logic [W-1:0] a0, n1, n2, w1;
    clearLogs();
    sinkHold[EAS] = 1'b1;
    a0 = mk(2'b11, 4'd3, 4'd2, 22'h500);
    n1 = mk(2'b11, 4'd3, 4'd2, 22'h501);
    n2 = mk(2'b11, 4'd3, 4'd2, 22'h502);
    w1 = mk(2'b11, 4'd3, 4'd2, 22'h503);
    sendRetry(NOR, a0);
    sendRetry(NOR, n1);
    sendRetry(NOR, n2);
    sendRetry(WES, w1);
    waitCycles(2);
    sinkHold[EAS] = 1'b0;
    waitCycles(8);
    check(logQ[EAS].size() == 4, "R9 count", 32'(logQ[EAS].size()), 4);
    if (logQ[EAS].size() == 4) begin
      check(logQ[EAS][0] == a0, "R9 first", logQ[EAS][0], a0);
      check(logQ[EAS][1] == w1, "R9 pointer past north picks west", logQ[EAS][1], w1);
      check(logQ[EAS][2] == n1, "R9 wrap to north", logQ[EAS][2], n1);
      check(logQ[EAS][3] == n2, "R9 last", logQ[EAS][3], n2);
    end
  endtask

  task automatic testStray();
    bit a, n;
    int total;
    clearLogs();
    sendFlit(SOU, mk(2'b00, 4'd3, 4'd2, 22'h600), a, n);
    check(!a && n, "R8 stray body refused", 32'({a, n}), 32'h1);
    sendFlit(SOU, mk(2'b10, 4'd3, 4'd2, 22'h601), a, n);
    check(!a && n, "R8 stray tail refused", 32'({a, n}), 32'h1);
    waitCycles(4);
    total = 0;
    for (int p = 0; p < 5; p++) total += logQ[p].size();
    check(total == 0, "R8 stray flits not forwarded", 32'(total), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    testReset();
    testDimOrder();
    testWestFirst();
    testNorthLast();
    testWormhole();
    testInterleave();
    testVcFull();
    testRoundRobin();
    testStray();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule